// File: doc/BRIEF.md
# Track-Swap Output Bit Corrector

This block turns the raw comparator bits of a successive-approximation time-to-digital converter that has a single set of delay lines into the true output code. In that converter all delays sit in one track and nothing restores the tracks after a stage. Each time the leading edge is steered into the other track's delay, the two events trade tracks. Every later comparator then reports the inverted order until another swap undoes it. A raw bit of 1 marks a swap. The true bit at a stage is therefore its raw bit XORed with the parity of all earlier raw bits, which is a prefix-XOR running from the most significant bit downwards. The top bit never needs correction.

The raw bits arrive in one of two ways. A whole raw word can come in on a one-cycle parallel strobe. Raw bits can also come in serially, MSB first, with a valid flag and a start-of-word flag on the first bit. In serial mode the corrected bit is returned combinationally in the same cycle as its raw bit. The corrected word is also assembled and presented as a parallel word once the last bit has been taken.

A three-state controller sequences the serial path. **IDLE** holds after reset. **SHIFT** is collecting a serial word. **HOLD** presents a finished word. The transitions are:
- *begin*: IDLE or HOLD to SHIFT, on an accepted start bit.
- *restart*: SHIFT to SHIFT, on a start bit in the middle of a word.
- *finish*: SHIFT to HOLD, on the N-th accepted bit.
- *load*: any state to HOLD, on the parallel strobe.

Top module: `track_swap_corrector`

## Requirements
- R1: After reset, `word_done` is 0, `word_out` is all zeros and `ser_corr_valid` is 0.
- R2: One cycle after `par_valid`, `word_out` holds the decoded word and `word_done` is 1. In the decoded word, bit N-1 equals raw bit N-1, and each lower bit k equals the XOR of raw bits N-1 down to k.
- R3: For an accepted serial bit, `ser_corr` in the same cycle equals the raw bit XORed with the parity of the raw bits accepted earlier in the same word. The bit carrying `ser_start` passes through unchanged.
- R4: `ser_corr_valid` is 1 in exactly the cycles in which a serial bit is accepted. A bit is accepted when `ser_valid` is 1, `par_valid` is 0, and either `ser_start` is 1 or a word is being collected. Idle gaps inside a word are allowed.
- R5: A start bit arriving in the middle of a word abandons that word. It clears the parity, and the bit count starts again from that bit.
- R6: One cycle after the N-th accepted bit of a word, `word_done` is 1. At that point `word_out` holds the corrected bits, with the first bit at position N-1 and the last bit at position 0.
- R7: While `word_done` is 1, `word_out` and `word_done` stay unchanged until a start bit is accepted or `par_valid` is asserted. Serial bits without `ser_start` are not accepted outside a word.
- R8: When `par_valid` coincides with serial input, the parallel word wins and the serial bit is not accepted.
- R9: `word_done` is 0 from the cycle after an accepted start bit until the word finishes. `word_out` keeps its old value during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_valid | input | 1 | Strobe for a whole raw word |
| par_raw | input | N | Raw comparator word, MSB = first stage |
| ser_valid | input | 1 | Serial raw bit present |
| ser_start | input | 1 | Serial bit is the first (MSB) of a word |
| ser_raw | input | 1 | Serial raw comparator bit |
| ser_corr_valid | output | 1 | Serial bit accepted this cycle |
| ser_corr | output | 1 | Corrected serial bit, same cycle |
| word_out | output | N | Corrected parallel word |
| word_done | output | 1 | A finished word is being presented |

## Verification
The assertions assume that every serial word opens with a bit carrying both `ser_valid` and `ser_start`. They also assume that `ser_start` is only meaningful while `ser_valid` is high. The stimulus builds its raw bits by passing a chosen true code through a model of the swapping converter. It always marks the first bit as the start and drops the flag on every other bit. Stray bits, mid-word restarts and collisions between the parallel and serial paths are produced as deliberate directed cases, and each keeps to these same framing rules.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_HOLD  = 2'd2
    } tsc_state_t;
endpackage

// File: rtl/tsc_prefix_decode.sv
// Parallel decode: each corrected bit is the XOR of all raw bits from the MSB
// down to and including itself (the running swap parity absorbs the raw bit).
module tsc_prefix_decode #(
    parameter int N = 8
) (
    input  logic [N-1:0] raw,
    output logic [N-1:0] corr
);
    logic [N-1:0] chain;

    assign chain[N-1] = raw[N-1];
    generate
        for (genvar k = N - 2; k >= 0; k--) begin : g_stage
            assign chain[k] = chain[k+1] ^ raw[k];
        end
    endgenerate

    assign corr = chain;
endmodule

// File: rtl/tsc_ser_parity.sv
// Serial swap-parity tracker: the corrected bit leaves in the same cycle.
module tsc_ser_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic start,
    input  logic raw,
    output logic corr
);
    logic parity_q;
    logic parity_eff;

    assign parity_eff = start ? 1'b0 : parity_q;
    assign corr       = raw ^ parity_eff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_q <= 1'b0;
        end else if (accept) begin
            parity_q <= parity_eff ^ raw;
        end
    end
endmodule

// File: rtl/tsc_word_fsm.sv
// Word controller: frames serial bits, assembles and presents finished words.
module tsc_word_fsm
    import tsc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_valid,
    input  logic [N-1:0] par_word,
    input  logic         ser_valid,
    input  logic         ser_start,
    input  logic         ser_corr,
    output logic         accept,
    output logic [N-1:0] word_out,
    output logic         word_done
);
    localparam int CW = $clog2(N + 1);

    tsc_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [N-1:0]  acc_q;
    logic [N-1:0]  word_q;
    logic          last_bit;

    assign accept   = ser_valid && !par_valid && (ser_start || st_q == S_SHIFT);
    assign last_bit = (cnt_q == CW'(N - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (accept) st_d = S_SHIFT;
            S_SHIFT: if (accept && !ser_start && last_bit) st_d = S_HOLD;
            S_HOLD:  if (accept) st_d = S_SHIFT;
            default: st_d = S_IDLE;
        endcase
        if (par_valid) st_d = S_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            word_q <= '0;
        end else if (par_valid) begin
            word_q <= par_word;
            cnt_q  <= '0;
        end else if (accept) begin
            if (ser_start) begin
                acc_q <= {{(N-1){1'b0}}, ser_corr};
                cnt_q <= CW'(1);
            end else begin
                acc_q <= {acc_q[N-2:0], ser_corr};
                cnt_q <= cnt_q + CW'(1);
                if (last_bit) word_q <= {acc_q[N-2:0], ser_corr};
            end
        end
    end

    assign word_out  = word_q;
    assign word_done = (st_q == S_HOLD);
endmodule

// File: rtl/track_swap_corrector.sv
module track_swap_corrector #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_valid,
    input  logic [N-1:0] par_raw,
    input  logic         ser_valid,
    input  logic         ser_start,
    input  logic         ser_raw,
    output logic         ser_corr_valid,
    output logic         ser_corr,
    output logic [N-1:0] word_out,
    output logic         word_done
);
    logic [N-1:0] par_word;
    logic         accept;

    tsc_prefix_decode #(.N(N)) u_dec (
        .raw  (par_raw),
        .corr (par_word)
    );

    tsc_ser_parity u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .start  (ser_start),
        .raw    (ser_raw),
        .corr   (ser_corr)
    );

    tsc_word_fsm #(.N(N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_valid (par_valid),
        .par_word  (par_word),
        .ser_valid (ser_valid),
        .ser_start (ser_start),
        .ser_corr  (ser_corr),
        .accept    (accept),
        .word_out  (word_out),
        .word_done (word_done)
    );

    assign ser_corr_valid = accept;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         par_valid,
    input logic [N-1:0] par_raw,
    input logic         ser_valid,
    input logic         ser_start,
    input logic         ser_raw,
    input logic         ser_corr_valid,
    input logic         ser_corr,
    input logic [N-1:0] word_out,
    input logic         word_done
);
    p_msb_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && ser_start && !par_valid) |-> (ser_corr == ser_raw));

    p_start_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && ser_start && !par_valid) |-> ser_corr_valid);

    p_par_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> !ser_corr_valid);

    p_par_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |=> (word_done && word_out[N-1] == $past(par_raw[N-1])));

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !par_valid && !(ser_valid && ser_start))
        |=> (word_done && $stable(word_out)));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && ser_start && !par_valid) |=> (!word_done && $stable(word_out)));
endmodule

bind track_swap_corrector tsc_checker #(.N(N)) u_tsc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .par_valid      (par_valid),
    .par_raw        (par_raw),
    .ser_valid      (ser_valid),
    .ser_start      (ser_start),
    .ser_raw        (ser_raw),
    .ser_corr_valid (ser_corr_valid),
    .ser_corr       (ser_corr),
    .word_out       (word_out),
    .word_done      (word_done)
);

// File: tb/track_swap_corrector_test.sv
module track_swap_corrector_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         par_valid = 1'b0;
    logic [N-1:0] par_raw = '0;
    logic         ser_valid = 1'b0;
    logic         ser_start = 1'b0;
    logic         ser_raw = 1'b0;
    logic         ser_corr_valid;
    logic         ser_corr;
    logic [N-1:0] word_out;
    logic         word_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    track_swap_corrector #(.N(N)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .par_valid      (par_valid),
        .par_raw        (par_raw),
        .ser_valid      (ser_valid),
        .ser_start      (ser_start),
        .ser_raw        (ser_raw),
        .ser_corr_valid (ser_corr_valid),
        .ser_corr       (ser_corr),
        .word_out       (word_out),
        .word_done      (word_done)
    );

    // Swapping converter model: a stage's raw bit is its true bit inverted when
    // an odd number of earlier stages swapped; a raw 1 is itself a swap.
    function automatic logic [N-1:0] swap_model(input logic [N-1:0] t);
        logic p;
        logic [N-1:0] r;
        p = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            r[k] = t[k] ^ p;
            p = p ^ r[k];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        par_valid = 1'b0;
        ser_valid = 1'b0;
        ser_start = 1'b0;
        ser_raw   = 1'b0;
    endtask

    // Serial word of true code t; optional single-cycle gaps between bits.
    task automatic ser_word(input logic [N-1:0] t, input bit gaps);
        logic [N-1:0] r;
        r = swap_model(t);
        for (int i = N - 1; i >= 0; i--) begin
            @(negedge clk);
            par_valid = 1'b0;
            ser_valid = 1'b1;
            ser_start = (i == N - 1);
            ser_raw   = r[i];
            #1;
            chk(ser_corr == t[i], "R3 serial corrected bit", 32'(ser_corr), 32'(t[i]));
            chk(ser_corr_valid == 1'b1, "R4 accept flag", 32'(ser_corr_valid), 1);
            if (gaps && i > 0 && ($urandom % 3 == 0)) begin
                @(negedge clk);
                idle_inputs();
                #1;
                chk(ser_corr_valid == 1'b0, "R4 gap not accepted", 32'(ser_corr_valid), 0);
                chk(word_done == 1'b0, "R9 busy during word", 32'(word_done), 0);
            end
        end
        @(negedge clk);
        idle_inputs();
        chk(word_done == 1'b1, "R6 word done", 32'(word_done), 1);
        chk(word_out == t, "R6 serial word", 32'(word_out), 32'(t));
    endtask

    task automatic par_word(input logic [N-1:0] t);
        @(negedge clk);
        par_valid = 1'b1;
        par_raw   = swap_model(t);
        @(negedge clk);
        idle_inputs();
        chk(word_done == 1'b1, "R2 parallel done", 32'(word_done), 1);
        chk(word_out == t, "R2 parallel decode", 32'(word_out), 32'(t));
    endtask

    initial begin
        logic [N-1:0] held;
        logic [N-1:0] r;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(word_done == 1'b0, "R1 reset done", 32'(word_done), 0);
        chk(word_out == '0, "R1 reset word", 32'(word_out), 0);
        chk(ser_corr_valid == 1'b0, "R1 reset valid", 32'(ser_corr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_done == 1'b0, "R1 idle after reset", 32'(word_done), 0);

        // R3/R6 directed corner codes
        ser_word('0, 1'b0);
        ser_word('1, 1'b0);
        ser_word({N/2{2'b10}}, 1'b0);
        ser_word({1'b1, {(N-1){1'b0}}}, 1'b0);
        // R2 directed
        par_word('1);
        par_word({N/2{2'b01}});
        par_word({(N){1'b0}});

        // R7: stray bits without start are ignored while holding
        held = word_out;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            ser_valid = 1'b1;
            ser_start = 1'b0;
            ser_raw   = 1'(j);
            #1;
            chk(ser_corr_valid == 1'b0, "R7 stray bit ignored", 32'(ser_corr_valid), 0);
        end
        @(negedge clk);
        idle_inputs();
        chk(word_out == held, "R7 word held", 32'(word_out), 32'(held));
        chk(word_done == 1'b1, "R7 done held", 32'(word_done), 1);

        // R9: start drops done, keeps old word
        held = word_out;
        r = swap_model(8'hA5);
        @(negedge clk);
        ser_valid = 1'b1; ser_start = 1'b1; ser_raw = r[N-1];
        @(negedge clk);
        ser_valid = 1'b1; ser_start = 1'b0; ser_raw = r[N-2];
        #1;
        chk(word_done == 1'b0, "R9 done dropped", 32'(word_done), 0);
        chk(word_out == held, "R9 old word kept", 32'(word_out), 32'(held));
        // R5: abandon and restart with a full word
        ser_word(8'h3C, 1'b0);

        // R8: parallel strobe collides with a start bit
        @(negedge clk);
        par_valid = 1'b1;
        par_raw   = swap_model(8'h96);
        ser_valid = 1'b1; ser_start = 1'b1; ser_raw = 1'b1;
        #1;
        chk(ser_corr_valid == 1'b0, "R8 serial blocked", 32'(ser_corr_valid), 0);
        @(negedge clk);
        idle_inputs();
        chk(word_out == 8'h96, "R8 parallel wins", 32'(word_out), 32'h96);
        chk(word_done == 1'b1, "R8 done", 32'(word_done), 1);
        // R8: collision mid-word aborts the serial word
        r = swap_model(8'h5A);
        @(negedge clk);
        ser_valid = 1'b1; ser_start = 1'b1; ser_raw = r[N-1];
        @(negedge clk);
        par_valid = 1'b1; par_raw = swap_model(8'h0F);
        ser_valid = 1'b1; ser_start = 1'b0; ser_raw = r[N-2];
        @(negedge clk);
        idle_inputs();
        ser_valid = 1'b1; ser_raw = 1'b1;
        #1;
        chk(ser_corr_valid == 1'b0, "R8 serial word aborted", 32'(ser_corr_valid), 0);
        chk(word_out == 8'h0F, "R8 mid-word parallel", 32'(word_out), 32'h0F);
        @(negedge clk);
        idle_inputs();

        // Random mix
        for (int n = 0; n < 200; n++) begin
            logic [N-1:0] t;
            t = N'($urandom);
            if ($urandom % 4 == 0) par_word(t);
            else ser_word(t, 1'b1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule